// File: doc/BRIEF.md
# Watchdog Timer with Ordered Service Sequence

The block is a watchdog countdown timer reached through a small 16-bit register bus. Software arms it by setting an enable bit in the control word. From then on a counter falls by one on every half-second tick supplied from outside. If software fails to reload it with a two-word service pattern before the count runs out, the block pulses a timeout reset, may pulse its external watchdog line, and records the cause.

An early-warning interrupt can be set to fire a programmable number of ticks before expiry. Software can also ask for a reset directly through the control word. Each reset event, whether from timeout or from software, returns every register to its reset value except the reset-cause register. That register then holds the cause of the most recent event until power-on reset.

Register offsets: control 0x0, service 0x2, reset cause 0x4, interrupt control 0x6, power-down control 0x8. Writes to other offsets are ignored, and reads of them return zero.

Top module: `wdt_guard`

## Requirements
- R1: After power-on reset (`rst_n` low) the control word reads 0x0030, the service and reset-cause offsets read 0, interrupt control reads 0, power-down control reads 1, and all pulse outputs are low.
- R2: Control bit 2 is the enable. Once it is 1, a control write with bit 2 equal to 0 leaves it at 1 until the next reset event or power-on reset.
- R3: Control bits 15:8 hold a value V. When the enable rises, or a service completes, the counter loads V+1. Each tick taken while enabled lowers the counter by one, so expiry comes on tick V+1.
- R4: A tick is not counted in any of these cases: `low_power` is high with control bit 0 set, `debug_mode` is high with control bit 1 set, or `wait_mode` is high with control bit 7 set.
- R5: On the tick that brings the counter to zero, `timeout_rst` is high for exactly the following cycle, the reset-cause register becomes 2 (bit 1), and every other register returns to its R1 value.
- R6: `wdog_out` is high while control bit 5 is 0. It is also high for the single cycle after expiry when control bit 3 was 1 at expiry.
- R7: A control write with bit 4 equal to 0 makes `sw_rst` high for the following cycle, sets the reset-cause register to 1 (bit 0), and returns the other registers to their R1 values. If a timeout happens in the same cycle, only the timeout is reported. Bit 4 always reads 1.
- R8: The counter reloads only when a service-register write of 0xAAAA directly follows a service-register write of 0x5555, and only while enabled. Any other service write returns the detector to idle without a reload. Accesses to other offsets do not disturb the detector.
- R9: Interrupt control has three fields: bits 7:0 hold the warning count P, bit 14 is the status, and bit 15 is the enable. The status sets on a counted tick that leaves the counter equal to P, provided P is nonzero. Writing 1 to bit 14 clears it, and a set in the same cycle wins. `wdog_irq` equals status AND enable.
- R10: Power-down control bit 0 is read/write, resets to 1, and drives `pwrdn_en`.
- R11: The reset-cause register is changed only by reset events, each of which overwrites it, and by power-on reset, which clears it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| tick | input | 1 | One-cycle half-second tick pulse |
| low_power | input | 1 | System is in low-power mode |
| debug_mode | input | 1 | System is halted for debug |
| wait_mode | input | 1 | System is in wait mode |
| bus_addr | input | 4 | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| timeout_rst | output | 1 | One-cycle reset pulse on expiry |
| sw_rst | output | 1 | One-cycle reset pulse on software request |
| wdog_out | output | 1 | External watchdog line |
| wdog_irq | output | 1 | Early-warning interrupt |
| pwrdn_en | output | 1 | Power-down enable |

## Verification
The bench builds the block with its default widths: an 8-bit timeout field and an 8-bit warning count, giving a 9-bit counter. Because the timeout value is programmable, small values such as 1 and 3 bring expiry, the warning interrupt and the reload race within a few dozen ticks. Ticks are spaced a few cycles apart, so service writes, write-one-to-clear and enable-clear attempts can fall between them. A behavioural model in the bench tracks every register and output and is compared with the design on every clock.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
    localparam int REG_W  = 16;
    localparam int TOUT_W = 8;
    localparam int PRE_W  = 8;
    localparam int CNT_W  = TOUT_W + 1;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] OFF_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] OFF_SVC  = 4'h2;
    localparam logic [ADDR_W-1:0] OFF_CAUSE = 4'h4;
    localparam logic [ADDR_W-1:0] OFF_ICR  = 4'h6;
    localparam logic [ADDR_W-1:0] OFF_PD   = 4'h8;

    localparam logic [REG_W-1:0] SVC_KEY_A = 16'h5555;
    localparam logic [REG_W-1:0] SVC_KEY_B = 16'hAAAA;
    localparam logic [REG_W-1:0] CTRL_INIT = 16'h0030;

    localparam int B_LPSUS = 0;
    localparam int B_DBSUS = 1;
    localparam int B_EN    = 2;
    localparam int B_TOPIN = 3;
    localparam int B_SWREQ = 4;
    localparam int B_PINN  = 5;
    localparam int B_WTSUS = 7;
    localparam int B_TV_LO = 8;
    localparam int B_ISTS  = 14;
    localparam int B_IEN   = 15;

    typedef struct packed {
        logic [REG_W-1:0] ctrl;
        logic [PRE_W-1:0] pre;
        logic             ists;
        logic             ien;
        logic             pd;
        logic [1:0]       cause;
        logic             tout;
        logic             swr;
        logic             pin;
    } regs_t;
endpackage

// File: rtl/wdt_guard_seq.sv
module wdt_guard_seq
    import wdt_guard_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr,
    input  logic [REG_W-1:0] data,
    output logic             reload
);
    logic armed_d, armed_q;

    always_comb begin
        armed_d = armed_q;
        reload  = 1'b0;
        if (wr) begin
            reload  = armed_q && (data == SVC_KEY_B);
            armed_d = !armed_q && (data == SVC_KEY_A);
        end
        if (clr) armed_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= armed_d;
    end

    // R8
    reload_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> !armed_q);
    // R8
    arm_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && data != SVC_KEY_A) |=> !armed_q);
endmodule

// File: rtl/wdt_guard_cnt.sv
module wdt_guard_cnt #(
    parameter int CW = 9,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          step,
    input  logic [PW-1:0] pre_val,
    output logic          expire,
    output logic          pre_hit
);
    logic [CW-1:0] cnt_d, cnt_q, nxt;

    always_comb begin
        cnt_d   = cnt_q;
        expire  = 1'b0;
        pre_hit = 1'b0;
        nxt     = cnt_q - 1'b1;
        if (load) begin
            cnt_d = load_val;
        end else if (step && cnt_q != '0) begin
            cnt_d   = nxt;
            expire  = (nxt == '0);
            pre_hit = (pre_val != '0) && (nxt == CW'(pre_val));
        end
        if (clr) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step && !clr) |=> $stable(cnt_q));
    // R5
    expire_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
    import wdt_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              low_power,
    input  logic              debug_mode,
    input  logic              wait_mode,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              timeout_rst,
    output logic              sw_rst,
    output logic              wdog_out,
    output logic              wdog_irq,
    output logic              pwrdn_en
);
    localparam regs_t REGS_INIT = '{ctrl: CTRL_INIT, pre: '0, ists: 1'b0, ien: 1'b0,
                                    pd: 1'b1, cause: 2'b00, tout: 1'b0, swr: 1'b0, pin: 1'b0};

    regs_t r_d, r_q;
    logic wr_ctrl, wr_svc, wr_icr, wr_pd, sw_req, suspend, step, ev;
    logic cnt_load, svc_reload, expire, pre_hit;
    logic [CNT_W-1:0] load_val;

    assign wr_ctrl = bus_we && (bus_addr == OFF_CTRL);
    assign wr_svc  = bus_we && (bus_addr == OFF_SVC);
    assign wr_icr  = bus_we && (bus_addr == OFF_ICR);
    assign wr_pd   = bus_we && (bus_addr == OFF_PD);

    wdt_guard_seq u_seq (
        .clk(clk), .rst_n(rst_n), .clr(ev), .wr(wr_svc),
        .data(bus_wdata), .reload(svc_reload)
    );

    wdt_guard_cnt #(.CW(CNT_W), .PW(PRE_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(ev), .load(cnt_load),
        .load_val(load_val), .step(step), .pre_val(r_q.pre),
        .expire(expire), .pre_hit(pre_hit)
    );

    always_comb begin
        sw_req   = wr_ctrl && !bus_wdata[B_SWREQ];
        suspend  = (low_power  && r_q.ctrl[B_LPSUS]) ||
                   (debug_mode && r_q.ctrl[B_DBSUS]) ||
                   (wait_mode  && r_q.ctrl[B_WTSUS]);
        step     = tick && r_q.ctrl[B_EN] && !suspend;
        cnt_load = (wr_ctrl && !r_q.ctrl[B_EN] && bus_wdata[B_EN]) ||
                   (svc_reload && r_q.ctrl[B_EN]);
        load_val = wr_ctrl ? CNT_W'(bus_wdata[B_TV_LO +: TOUT_W]) + 1'b1
                           : CNT_W'(r_q.ctrl[B_TV_LO +: TOUT_W]) + 1'b1;
        ev       = expire || sw_req;

        r_d      = r_q;
        r_d.tout = 1'b0;
        r_d.swr  = 1'b0;
        r_d.pin  = 1'b0;
        if (ev) begin
            r_d       = REGS_INIT;
            r_d.cause = expire ? 2'b10 : 2'b01;
            r_d.tout  = expire;
            r_d.swr   = !expire;
            r_d.pin   = expire && r_q.ctrl[B_TOPIN];
        end else begin
            if (wr_ctrl) begin
                r_d.ctrl         = bus_wdata;
                r_d.ctrl[B_EN]   = bus_wdata[B_EN] || r_q.ctrl[B_EN];
                r_d.ctrl[B_SWREQ] = 1'b1;
            end
            if (wr_icr) begin
                r_d.pre = bus_wdata[PRE_W-1:0];
                r_d.ien = bus_wdata[B_IEN];
                if (bus_wdata[B_ISTS]) r_d.ists = 1'b0;
            end
            if (pre_hit) r_d.ists = 1'b1;
            if (wr_pd) r_d.pd = bus_wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_INIT;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_CTRL:  bus_rdata = r_q.ctrl;
            OFF_CAUSE: bus_rdata = REG_W'(r_q.cause);
            OFF_ICR: begin
                bus_rdata[PRE_W-1:0] = r_q.pre;
                bus_rdata[B_ISTS]    = r_q.ists;
                bus_rdata[B_IEN]     = r_q.ien;
            end
            OFF_PD:    bus_rdata = REG_W'(r_q.pd);
            default:   bus_rdata = '0;
        endcase
    end

    assign timeout_rst = r_q.tout;
    assign sw_rst      = r_q.swr;
    assign wdog_out    = !r_q.ctrl[B_PINN] || r_q.pin;
    assign wdog_irq    = r_q.ists && r_q.ien;
    assign pwrdn_en    = r_q.pd;

    // R2
    en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ctrl[B_EN] && !ev) |=> r_q.ctrl[B_EN]);
    // R5
    tout_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_rst |=> !timeout_rst);
    // R5
    tout_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_rst |-> (r_q.cause == 2'b10 && !r_q.ctrl[B_EN]));
    // R7
    sw_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |-> (r_q.cause == 2'b01));
    // R11
    cause_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(r_q.cause));
    // R11
    cause_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ev |=> $stable(r_q.cause));
endmodule

// File: tb/tb_wdt_guard.sv
module tb_wdt_guard;
    localparam int CLK_P = 10;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
    logic low_power = 1'b0, debug_mode = 1'b0, wait_mode = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic bus_we = 1'b0;
    logic [15:0] bus_wdata = 16'h0, bus_rdata;
    logic timeout_rst, sw_rst, wdog_out, wdog_irq, pwrdn_en;

    int total = 0, bad = 0, tout_seen = 0, started = 0;

    // behavioural reference state
    logic [15:0] m_ctrl;
    logic [7:0]  m_pre;
    logic        m_ists, m_ien, m_pd, m_armed;
    logic [1:0]  m_cause;
    int          m_cnt;
    logic        e_tout, e_swr, e_pin;

    always #(CLK_P/2) clk = ~clk;

    wdt_guard dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .low_power(low_power),
        .debug_mode(debug_mode), .wait_mode(wait_mode), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .timeout_rst(timeout_rst), .sw_rst(sw_rst), .wdog_out(wdog_out),
        .wdog_irq(wdog_irq), .pwrdn_en(pwrdn_en)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_init();
        m_ctrl = 16'h0030; m_pre = 8'h0; m_ists = 1'b0; m_ien = 1'b0;
        m_pd = 1'b1; m_armed = 1'b0; m_cnt = 0;
    endtask

    function automatic logic [15:0] m_read(input logic [3:0] a);
        case (a)
            4'h0: return m_ctrl;
            4'h4: return {14'h0, m_cause};
            4'h6: return {m_ien, m_ists, 6'h0, m_pre};
            4'h8: return {15'h0, m_pd};
            default: return 16'h0;
        endcase
    endfunction

    function automatic string rd_tag(input logic [3:0] a);
        case (a)
            4'h0: return "R2 ctrl";
            4'h4: return "R11 cause";
            4'h6: return "R9 icr";
            4'h8: return "R10 pd";
            default: return "R8 svc";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            model_init();
            m_cause = 2'b00; e_tout = 0; e_swr = 0; e_pin = 0;
        end else begin
            bit swq, ld, expd, hit, run;
            int lv;
            swq = bus_we && bus_addr == 4'h0 && !bus_wdata[4];
            run = m_ctrl[2] && !(low_power && m_ctrl[0]) && !(debug_mode && m_ctrl[1])
                  && !(wait_mode && m_ctrl[7]);
            ld = 0; lv = 0; expd = 0; hit = 0;
            if (bus_we && bus_addr == 4'h0 && !m_ctrl[2] && bus_wdata[2]) begin
                ld = 1; lv = int'(bus_wdata[15:8]) + 1;
            end
            if (bus_we && bus_addr == 4'h2) begin
                if (m_armed && bus_wdata == 16'hAAAA && m_ctrl[2]) begin
                    ld = 1; lv = int'(m_ctrl[15:8]) + 1;
                end
                m_armed = !m_armed && bus_wdata == 16'h5555;
            end
            e_tout = 0; e_swr = 0; e_pin = 0;
            if (ld) m_cnt = lv;
            else if (tick && run && m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) expd = 1;
                if (m_pre != 0 && m_cnt == int'(m_pre)) hit = 1;
            end
            if (expd || swq) begin
                e_pin = expd && m_ctrl[3];
                model_init();
                m_cause = expd ? 2'b10 : 2'b01;
                e_tout = expd; e_swr = !expd;
            end else begin
                if (bus_we && bus_addr == 4'h0) begin
                    m_ctrl = bus_wdata | {13'h0, m_ctrl[2], 2'b00} | 16'h0010;
                end
                if (bus_we && bus_addr == 4'h6) begin
                    m_pre = bus_wdata[7:0]; m_ien = bus_wdata[15];
                    if (bus_wdata[14]) m_ists = 1'b0;
                end
                if (hit) m_ists = 1'b1;
                if (bus_we && bus_addr == 4'h8) m_pd = bus_wdata[0];
            end
        end
        #(CLK_P/4);
        if (rst_n && started != 0) begin
            check("R3 R4 R5 timeout_rst", timeout_rst, e_tout);
            check("R7 sw_rst", sw_rst, e_swr);
            check("R6 wdog_out", wdog_out, !m_ctrl[5] || e_pin);
            check("R9 wdog_irq", wdog_irq, m_ists && m_ien);
            check("R10 pwrdn_en", pwrdn_en, m_pd);
            check(rd_tag(bus_addr), bus_rdata, m_read(bus_addr));
            if (timeout_rst) tout_seen++;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic peek(input logic [3:0] a, input int exp, input string tag);
        @(negedge clk); bus_addr = a; #1;
        check(tag, bus_rdata, exp);
    endtask

    initial begin
        #(CLK_P * 100000);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1; started = 1;
        // R1 reset values
        peek(4'h0, 16'h0030, "R1 ctrl reset");
        peek(4'h2, 16'h0000, "R1 svc reset");
        peek(4'h4, 16'h0000, "R1 cause reset");
        peek(4'h6, 16'h0000, "R1 icr reset");
        peek(4'h8, 16'h0001, "R1 pd reset");
        check("R1 outputs", {timeout_rst, sw_rst, wdog_out, wdog_irq}, 0);
        // R10 power-down bit
        wr(4'h8, 16'h0000); peek(4'h8, 0, "R10 pd clear");
        wr(4'h8, 16'hFFFF); peek(4'h8, 1, "R10 pd set");
        // R3 ticks while disabled do nothing
        ticks(3, 1);
        // arm: V=3, pin on timeout, warning P=2 with irq enabled
        wr(4'h6, 16'h8002);
        wr(4'h0, 16'h033C);
        peek(4'h0, 16'h033C, "R2 enabled");
        ticks(2, 2);
        check("R9 irq after warning", wdog_irq, 1);
        wr(4'h6, 16'hC002);
        peek(4'h6, 16'h8002, "R9 w1c");
        // R2 clearing enable ignored
        wr(4'h0, 16'h0338);
        peek(4'h0, 16'h033C, "R2 sticky");
        // R8 broken sequence: no reload
        wr(4'h2, 16'h5555); wr(4'h2, 16'h1234); wr(4'h2, 16'hAAAA);
        wr(4'h2, 16'h5555); wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
        ticks(1, 2);
        // R8 good sequence with another access between
        wr(4'h2, 16'h5555); wr(4'h8, 16'h0001); wr(4'h2, 16'hAAAA);
        ticks(3, 2);
        check("R8 reload held off expiry", tout_seen, 0);
        ticks(1, 3);
        check("R3 R5 expiry count", tout_seen, 1);
        peek(4'h4, 2, "R5 cause timeout");
        peek(4'h0, 16'h0030, "R5 ctrl reinit");
        // R4 suspension: V=1 with all suspend bits
        wr(4'h0, 16'h01B7);
        low_power = 1'b1; ticks(2, 1); low_power = 1'b0;
        debug_mode = 1'b1; ticks(2, 1); debug_mode = 1'b0;
        wait_mode = 1'b1; ticks(2, 1); wait_mode = 1'b0;
        check("R4 suspended no expiry", tout_seen, 1);
        ticks(2, 3);
        check("R4 resumed expiry", tout_seen, 2);
        peek(4'h4, 2, "R11 cause after second timeout");
        // R6 software assertion of the external line
        wr(4'h0, 16'h0010);
        check("R6 pin asserted", wdog_out, 1);
        wr(4'h0, 16'h0030);
        check("R6 pin released", wdog_out, 0);
        // R7 software reset
        wr(4'h0, 16'h0004);
        peek(4'h4, 1, "R7 cause software");
        peek(4'h0, 16'h0030, "R7 ctrl reinit");
        // R11 power-on reset clears cause
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        peek(4'h4, 0, "R11 cleared by power-on");
        repeat (4) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule